// File: doc/BRIEF.md
# Branch and Skip Next-PC Unit

This unit resolves where a control-flow instruction sends the program counter and how many execution cycles that instruction costs. Each cycle the decoder may present one already-classified instruction: its own PC, an instruction class, a signed displacement, the return address popped by the stack logic, a status-bit selector with the value the branch tests for, the status flags, the comparison outcome of a skip, and whether the instruction that follows is two words long. One clock later the unit presents the resolved PC and the cycle cost. Opcode decoding, stack storage and interrupt handling stay outside the unit.

The covered classes are sequential flow, relative jump, relative call, return, conditional branch on any single status bit, conditional branch on the signed less-than condition, and skip. The skip distance depends on the length of the instruction being skipped. Every PC sum wraps modulo the program memory size.

Class encoding on `in_class`: 0 sequential, 1 jump, 2 call, 3 return, 4 branch on a status bit, 5 signed branch, 6 skip, 7 reserved (treated as sequential). Status flag bit positions in `in_sreg`: bit 0 carry, bit 1 zero, bit 2 negative, bit 3 overflow, bit 4 sign, bits 5 to 7 half-carry, transfer bit and interrupt enable.

Top module: `nxpc_unit`

## Requirements
- R1: During and directly after reset, `out_valid`, `out_pc` and `out_cycles` are all zero.
- R2: `out_valid` in a cycle equals `in_valid` of the previous cycle, and the result belongs to the instruction presented in that previous cycle.
- R3: Class 0 and the reserved class 7 give `in_pc + 1` with a cost of 1 cycle.
- R4: A jump (class 1) gives `in_pc + sext(in_disp[11:0]) + 1` with a cost of 2 cycles.
- R5: A call (class 2) gives the same target as a jump with a cost of 3 cycles.
- R6: A return (class 3) gives `in_ret_pc` with a cost of 4 cycles.
- R7: A status branch (class 4) is taken when `in_sreg[in_bit_sel]` equals `in_polarity`. A taken branch gives `in_pc + sext(in_disp[6:0]) + 1` in 2 cycles. An untaken branch gives `in_pc + 1` in 1 cycle. Bits 11 to 7 of `in_disp` have no effect on a branch. With `in_bit_sel` = 0, polarity 0 is the unsigned same-or-higher test and polarity 1 is the unsigned lower test.
- R8: A signed branch (class 5) compares negative XOR overflow (`in_sreg[2] ^ in_sreg[3]`) with `in_polarity`. Polarity 0 is greater-or-equal and polarity 1 is less-than. `in_bit_sel` and the stored sign bit `in_sreg[4]` have no effect. Target and cost are as in R7.
- R9: A skip (class 6) whose condition `in_skip_hit` is 0 gives `in_pc + 1` in 1 cycle. A hit over a one-word instruction gives `in_pc + 2` in 2 cycles. A hit over a two-word instruction (`in_next_long` = 1) gives `in_pc + 3` in 3 cycles.
- R10: Every computed PC wraps modulo 2^PC_W, forward past the top of memory and backward below address zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An instruction is presented this cycle |
| in_class | input | 3 | Instruction class (encoding above) |
| in_pc | input | PC_W (10) | PC of the presented instruction |
| in_disp | input | LONG_DISP_W (12) | Signed displacement; branches use the low SHORT_DISP_W (7) bits |
| in_ret_pc | input | PC_W (10) | Return address supplied by the stack logic |
| in_bit_sel | input | 3 | Status bit tested by a class 4 branch |
| in_polarity | input | 1 | Value the tested condition must equal for the branch to be taken |
| in_sreg | input | 8 | Status flags |
| in_skip_hit | input | 1 | Skip condition outcome |
| in_next_long | input | 1 | The following instruction is two words long |
| out_valid | output | 1 | A result is present |
| out_pc | output | PC_W (10) | Resolved next PC |
| out_cycles | output | 3 | Execution cycles of the instruction |

## Verification
On every cycle the assertions check the fixed costs of jump, call and return, the return address pass-through, the sequential and missed-skip step of one, the rule that a one-cycle branch always lands on the next word, and the one-cycle valid pipeline. Only the bench scenarios can show the displacement arithmetic itself. That covers sign extension of the two displacement widths, wrap across both ends of memory, and the choice between the status-bit path and the negative-XOR-overflow path when the stored sign bit contradicts them. They also show the two-word skip distance. A seeded random mix of all classes runs alongside directed corner cases.

// File: rtl/nxpc_pkg.sv
package nxpc_pkg;

    typedef enum logic [2:0] {
        CLS_SEQ           = 3'd0,
        CLS_JUMP          = 3'd1,
        CLS_CALL          = 3'd2,
        CLS_RET           = 3'd3,
        CLS_BRANCH        = 3'd4,
        CLS_BRANCH_SIGNED = 3'd5,
        CLS_SKIP          = 3'd6,
        CLS_RSVD          = 3'd7
    } nxpc_class_e;

    // status flag positions the signed condition depends on
    localparam int FLAG_NEG = 2;
    localparam int FLAG_OVF = 3;

    localparam int CYC_W = 3;

    localparam logic [CYC_W-1:0] CYC_ONE   = 3'd1;
    localparam logic [CYC_W-1:0] CYC_JUMP  = 3'd2;
    localparam logic [CYC_W-1:0] CYC_CALL  = 3'd3;
    localparam logic [CYC_W-1:0] CYC_RET   = 3'd4;
    localparam logic [CYC_W-1:0] CYC_TAKEN = 3'd2;

endpackage

// File: rtl/nxpc_disp_add.sv
// Relative target: pc + sign-extended displacement + 1, wrapped to PC_W bits.
module nxpc_disp_add #(
    parameter int PC_W   = 10,
    parameter int DISP_W = 12
) (
    input  logic [PC_W-1:0]   pc,
    input  logic [DISP_W-1:0] disp,
    output logic [PC_W-1:0]   target
);
    localparam int SUM_W = ((PC_W > DISP_W) ? PC_W : DISP_W) + 1;

    logic signed [SUM_W-1:0] disp_ext;
    logic        [SUM_W-1:0] sum;

    always_comb begin
        disp_ext = SUM_W'($signed(disp));
        sum      = SUM_W'(pc) + disp_ext + SUM_W'(1);
        target   = sum[PC_W-1:0];
    end
endmodule

// File: rtl/nxpc_cond.sv
// Branch condition: either one selected status bit or negative XOR overflow.
module nxpc_cond
    import nxpc_pkg::*;
#(
    parameter  int FLAG_W = 8,
    localparam int SEL_W  = $clog2(FLAG_W)
) (
    input  logic [FLAG_W-1:0] sreg,
    input  logic [SEL_W-1:0]  sel,
    input  logic              polarity,
    input  logic              signed_mode,
    output logic              taken
);
    logic tested;

    always_comb begin
        if (signed_mode) begin
            tested = sreg[FLAG_NEG] ^ sreg[FLAG_OVF];
        end else begin
            tested = sreg[sel];
        end
        taken = (tested == polarity);
    end
endmodule

// File: rtl/nxpc_skip.sv
// Skip distance and cost: over nothing, a one-word or a two-word instruction.
module nxpc_skip
    import nxpc_pkg::*;
(
    input  logic             hit,
    input  logic             next_long,
    output logic [1:0]       step,
    output logic [CYC_W-1:0] cycles
);
    always_comb begin
        if (!hit) begin
            step   = 2'd1;
            cycles = 3'd1;
        end else if (next_long) begin
            step   = 2'd3;
            cycles = 3'd3;
        end else begin
            step   = 2'd2;
            cycles = 3'd2;
        end
    end
endmodule

// File: rtl/nxpc_unit.sv
module nxpc_unit
    import nxpc_pkg::*;
#(
    parameter  int PC_W         = 10,
    parameter  int LONG_DISP_W  = 12,
    parameter  int SHORT_DISP_W = 7,
    parameter  int FLAG_W       = 8,
    localparam int SEL_W        = $clog2(FLAG_W)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [2:0]             in_class,
    input  logic [PC_W-1:0]        in_pc,
    input  logic [LONG_DISP_W-1:0] in_disp,
    input  logic [PC_W-1:0]        in_ret_pc,
    input  logic [SEL_W-1:0]       in_bit_sel,
    input  logic                   in_polarity,
    input  logic [FLAG_W-1:0]      in_sreg,
    input  logic                   in_skip_hit,
    input  logic                   in_next_long,
    output logic                   out_valid,
    output logic [PC_W-1:0]        out_pc,
    output logic [CYC_W-1:0]       out_cycles
);
    typedef struct packed {
        logic             valid;
        logic [PC_W-1:0]  pc;
        logic [CYC_W-1:0] cyc;
    } nxpc_state_t;

    nxpc_state_t st_d, st_q;

    nxpc_class_e      cls;
    logic [PC_W-1:0]  long_tgt;
    logic [PC_W-1:0]  short_tgt;
    logic [PC_W-1:0]  seq_pc;
    logic [PC_W-1:0]  skip_pc;
    logic             br_taken;
    logic [1:0]       skip_step;
    logic [CYC_W-1:0] skip_cyc;

    assign cls = nxpc_class_e'(in_class);

    nxpc_disp_add #(.PC_W(PC_W), .DISP_W(LONG_DISP_W)) u_long_add (
        .pc     (in_pc),
        .disp   (in_disp),
        .target (long_tgt)
    );

    nxpc_disp_add #(.PC_W(PC_W), .DISP_W(SHORT_DISP_W)) u_short_add (
        .pc     (in_pc),
        .disp   (in_disp[SHORT_DISP_W-1:0]),
        .target (short_tgt)
    );

    nxpc_cond #(.FLAG_W(FLAG_W)) u_cond (
        .sreg        (in_sreg),
        .sel         (in_bit_sel),
        .polarity    (in_polarity),
        .signed_mode (cls == CLS_BRANCH_SIGNED),
        .taken       (br_taken)
    );

    nxpc_skip u_skip (
        .hit       (in_skip_hit),
        .next_long (in_next_long),
        .step      (skip_step),
        .cycles    (skip_cyc)
    );

    always_comb begin
        seq_pc  = in_pc + PC_W'(1);
        skip_pc = in_pc + PC_W'(skip_step);

        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            unique case (cls)
                CLS_JUMP: begin
                    st_d.pc  = long_tgt;
                    st_d.cyc = CYC_JUMP;
                end
                CLS_CALL: begin
                    st_d.pc  = long_tgt;
                    st_d.cyc = CYC_CALL;
                end
                CLS_RET: begin
                    st_d.pc  = in_ret_pc;
                    st_d.cyc = CYC_RET;
                end
                CLS_BRANCH, CLS_BRANCH_SIGNED: begin
                    st_d.pc  = br_taken ? short_tgt : seq_pc;
                    st_d.cyc = br_taken ? CYC_TAKEN : CYC_ONE;
                end
                CLS_SKIP: begin
                    st_d.pc  = skip_pc;
                    st_d.cyc = skip_cyc;
                end
                default: begin
                    st_d.pc  = seq_pc;
                    st_d.cyc = CYC_ONE;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid  = st_q.valid;
    assign out_pc     = st_q.pc;
    assign out_cycles = st_q.cyc;

    // ---------------- assertions ----------------
    assert_valid_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_valid_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_seq_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_class == 3'd0 || in_class == 3'd7))
        |=> (out_pc == $past(in_pc) + PC_W'(1)) && (out_cycles == 3'd1));

    assert_jump_cost_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_class == 3'd1) |=> out_cycles == 3'd2);

    assert_call_cost_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_class == 3'd2) |=> out_cycles == 3'd3);

    assert_ret_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_class == 3'd3)
        |=> (out_pc == $past(in_ret_pc)) && (out_cycles == 3'd4));

    assert_branch_cost_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_class == 3'd4 || in_class == 3'd5))
        |=> (out_cycles == 3'd1 || out_cycles == 3'd2));

    assert_branch_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_class == 3'd4 || in_class == 3'd5))
        |=> (out_cycles == 3'd1) -> (out_pc == $past(in_pc) + PC_W'(1)));

    assert_skip_miss_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_class == 3'd6 && !in_skip_hit)
        |=> (out_pc == $past(in_pc) + PC_W'(1)) && (out_cycles == 3'd1));

    assert_skip_cost_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_class == 3'd6 && in_skip_hit)
        |=> out_cycles == (in_next_long ? 3'd3 : 3'd2) || $past(in_next_long) == (out_cycles == 3'd3));

endmodule

// File: tb/test_nxpc_unit.sv
module test_nxpc_unit;
    localparam int PW = 10;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           in_valid = 1'b0;
    logic [2:0]     in_class = '0;
    logic [PW-1:0]  in_pc = '0;
    logic [11:0]    in_disp = '0;
    logic [PW-1:0]  in_ret_pc = '0;
    logic [2:0]     in_bit_sel = '0;
    logic           in_polarity = 1'b0;
    logic [7:0]     in_sreg = '0;
    logic           in_skip_hit = 1'b0;
    logic           in_next_long = 1'b0;
    logic           out_valid;
    logic [PW-1:0]  out_pc;
    logic [2:0]     out_cycles;

    int n_checks = 0;
    int n_fails  = 0;

    always #10 clk = ~clk;

    nxpc_unit i_nxpc_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_class(in_class),
        .in_pc(in_pc), .in_disp(in_disp), .in_ret_pc(in_ret_pc),
        .in_bit_sel(in_bit_sel), .in_polarity(in_polarity), .in_sreg(in_sreg),
        .in_skip_hit(in_skip_hit), .in_next_long(in_next_long),
        .out_valid(out_valid), .out_pc(out_pc), .out_cycles(out_cycles)
    );

    function automatic logic [PW-1:0] rel(input logic [PW-1:0] pc, input int offs);
        int s;
        s = int'(pc) + offs + 1;
        return PW'(s & ((1 << PW) - 1));
    endfunction

    function automatic void model(input logic [2:0] c, input logic [PW-1:0] pc,
                                  input logic [11:0] d, input logic [PW-1:0] rp,
                                  input logic [2:0] sel, input logic pol,
                                  input logic [7:0] sr, input logic hit, input logic lng,
                                  output logic [PW-1:0] epc, output logic [2:0] ecyc);
        int  long_off;
        int  short_off;
        logic cond;
        long_off  = int'($signed(d));
        short_off = int'($signed(d[6:0]));
        epc  = rel(pc, 0);
        ecyc = 3'd1;
        case (c)
            3'd1: begin epc = rel(pc, long_off); ecyc = 3'd2; end
            3'd2: begin epc = rel(pc, long_off); ecyc = 3'd3; end
            3'd3: begin epc = rp; ecyc = 3'd4; end
            3'd4, 3'd5: begin
                cond = (c == 3'd5) ? (sr[2] ^ sr[3]) : sr[sel];
                if (cond == pol) begin epc = rel(pc, short_off); ecyc = 3'd2; end
            end
            3'd6: begin
                if (hit) begin
                    epc  = rel(pc, lng ? 2 : 1);
                    ecyc = lng ? 3'd3 : 3'd2;
                end
            end
            default: ;
        endcase
    endfunction

    function automatic string req_of(input logic [2:0] c);
        case (c)
            3'd1: return "R4";
            3'd2: return "R5";
            3'd3: return "R6";
            3'd4: return "R7";
            3'd5: return "R8";
            3'd6: return "R9";
            default: return "R3";
        endcase
    endfunction

    task automatic run_op(input logic [2:0] c, input logic [PW-1:0] pc,
                          input logic [11:0] d, input logic [PW-1:0] rp,
                          input logic [2:0] sel, input logic pol, input logic [7:0] sr,
                          input logic hit, input logic lng, input string tag);
        logic [PW-1:0] epc;
        logic [2:0]    ecyc;
        in_valid = 1'b1; in_class = c; in_pc = pc; in_disp = d; in_ret_pc = rp;
        in_bit_sel = sel; in_polarity = pol; in_sreg = sr;
        in_skip_hit = hit; in_next_long = lng;
        model(c, pc, d, rp, sel, pol, sr, hit, lng, epc, ecyc);
        @(negedge clk);
        n_checks++;
        if (out_valid !== 1'b1 || out_pc !== epc || out_cycles !== ecyc) begin
            n_fails++;
            $display("FAIL %s class=%0d actual valid=%b pc=%0d cyc=%0d expected valid=1 pc=%0d cyc=%0d",
                     tag, c, out_valid, out_pc, out_cycles, epc, ecyc);
        end
    endtask

    task automatic idle_check();
        in_valid = 1'b0;
        @(negedge clk);
        n_checks++;
        if (out_valid !== 1'b0) begin
            n_fails++;
            $display("FAIL R2 idle actual valid=%b expected valid=0", out_valid);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        n_checks++;
        if (out_valid !== 1'b0 || out_pc !== '0 || out_cycles !== '0) begin
            n_fails++;
            $display("FAIL R1 reset actual valid=%b pc=%0d cyc=%0d expected 0 0 0",
                     out_valid, out_pc, out_cycles);
        end
        rst_n = 1'b1;
        @(negedge clk);
        n_checks++;
        if (out_valid !== 1'b0 || out_pc !== '0 || out_cycles !== '0) begin
            n_fails++;
            $display("FAIL R1 after release actual valid=%b pc=%0d cyc=%0d expected 0 0 0",
                     out_valid, out_pc, out_cycles);
        end

        // directed corners
        run_op(3'd0, 10'd1023, 12'd0, 10'd0, 3'd0, 1'b0, 8'h00, 1'b0, 1'b0, "R3 R10 seq wrap");
        run_op(3'd7, 10'd40, 12'd0, 10'd0, 3'd0, 1'b0, 8'h00, 1'b0, 1'b0, "R3 reserved");
        run_op(3'd1, 10'd1000, 12'd100, 10'd0, 3'd0, 1'b0, 8'h00, 1'b0, 1'b0, "R4 R10 fwd wrap");
        run_op(3'd1, 10'd5, 12'hFF0, 10'd0, 3'd0, 1'b0, 8'h00, 1'b0, 1'b0, "R4 R10 back wrap");
        run_op(3'd1, 10'd300, 12'h800, 10'd0, 3'd0, 1'b0, 8'h00, 1'b0, 1'b0, "R4 min disp");
        run_op(3'd2, 10'd20, 12'h7FF, 10'd0, 3'd0, 1'b0, 8'h00, 1'b0, 1'b0, "R5 max disp");
        run_op(3'd3, 10'd77, 12'd9, 10'd612, 3'd0, 1'b0, 8'h00, 1'b0, 1'b0, "R6 ret");
        run_op(3'd4, 10'd100, 12'hF85, 10'd0, 3'd0, 1'b0, 8'h00, 1'b0, 1'b0, "R7 same-or-higher upper disp ignored");
        run_op(3'd4, 10'd100, 12'h040, 10'd0, 3'd0, 1'b1, 8'h00, 1'b0, 1'b0, "R7 lower not taken");
        run_op(3'd4, 10'd2, 12'h07C, 10'd0, 3'd1, 1'b1, 8'h02, 1'b0, 1'b0, "R7 R10 back wrap zero flag");
        run_op(3'd5, 10'd200, 12'h010, 10'd0, 3'd4, 1'b0, 8'h14, 1'b0, 1'b0, "R8 ge sign bit ignored");
        run_op(3'd5, 10'd200, 12'h010, 10'd0, 3'd4, 1'b1, 8'h04, 1'b0, 1'b0, "R8 lt taken sign bit clear");
        run_op(3'd5, 10'd200, 12'h010, 10'd0, 3'd2, 1'b1, 8'h1C, 1'b0, 1'b0, "R8 lt not taken");
        run_op(3'd6, 10'd50, 12'd0, 10'd0, 3'd0, 1'b0, 8'h00, 1'b0, 1'b1, "R9 miss");
        run_op(3'd6, 10'd50, 12'd0, 10'd0, 3'd0, 1'b0, 8'h00, 1'b1, 1'b0, "R9 hit short");
        run_op(3'd6, 10'd1022, 12'd0, 10'd0, 3'd0, 1'b0, 8'h00, 1'b1, 1'b1, "R9 R10 hit long wrap");
        idle_check();

        // seeded random mix
        void'($urandom(32'd20240611));
        for (int i = 0; i < 3000; i++) begin
            logic [2:0] c;
            c = 3'($urandom);
            run_op(c, PW'($urandom), 12'($urandom), PW'($urandom), 3'($urandom),
                   1'($urandom), 8'($urandom), 1'($urandom), 1'($urandom), req_of(c));
            if ((i % 97) == 0) idle_check();
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL R2 watchdog actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule